// File: doc/BRIEF.md
# Transport Packet Buffer Writer

This block takes a byte stream of already filtered 188-byte transport packets and writes each byte to a host buffer through a simple memory write port. The buffer holds a fixed number of packets, eight by default. It starts at a base address that software programs. The block counts the complete packets stored since the last rewind. It reports that count, together with its event flags, masks and control fields, in one 32-bit control/status word.

Four events can raise the interrupt line:

- the packet count reaching a programmable threshold,
- the buffer reaching one packet short of full,
- a packet arriving while the buffer is full,
- a rising edge on the demodulator lock input.

Software normally sets the threshold to half the buffer. It handles the data, acknowledges the flags, and rewinds the write pointer by rewriting the base address. Clearing the run bit holds the stream logic in reset, and setting it again restarts the logic at the base address.

Top module: `ts_buf_writer`

## Requirements
- R1: After reset the status word reads 0x00027004. This means all four masks are set, run is 0, the threshold is 4 and the count is 0. In this state irq_o is low and no memory write occurs.
- R2: Each accepted byte is written exactly once, unchanged, one cycle after it is accepted. Writes go to consecutive byte addresses starting at the base, and packet n of the buffer begins at base + 188*n.
- R3: Status bits 31:24 hold the number of complete packets stored. This count rises by one at the clock edge that accepts the final (188th) byte of a packet.
- R4: The done flag (status bit 16) is set when a packet completes and the count reaches the threshold in bits 6:0. A threshold of 0 never sets the flag.
- R5: The almost-full flag (bit 10) is set when a completing packet brings the count to the buffer size minus one.
- R6: If a packet starts while the count equals the buffer size, the overflow flag (bit 11) is set. All 188 bytes of that packet are dropped: no memory writes occur and the count does not change.
- R7: The lock flag (bit 9) is set on a rising edge of lock_i. Holding lock_i high does not set the flag again.
- R8: irq_o is high exactly when some flag is set whose mask bit is 0. The mask bits are 17 for done, 14 for overflow, 13 for almost-full and 12 for lock. Setting a mask bit does not clear its flag.
- R9: Writing the control/status word with bit 8 set clears all four flags. An event in the same cycle wins over the clear. Bit 8 always reads 0.
- R10: While run (bit 15) is 0, the count is held at 0 and input bytes are ignored. When run is set again, writing restarts at the base address.
- R11: Writing the base register (reg_sel_i = 1) rewinds the buffer. The count becomes 0 and the next accepted byte is written at the new base. A byte presented in the same cycle as the base write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Packet byte present this cycle |
| byte_i | input | 8 | Packet byte |
| lock_i | input | 1 | Demodulator lock level |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = control/status, 1 = base address |
| reg_wdata_i | input | 32 | Register write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_data_o | output | 8 | Memory write data |
| status_o | output | 32 | Control/status word |
| irq_o | output | 1 | Interrupt request |

## Verification
Memory writes appear one cycle after each byte is accepted. The count, every flag and irq_o change at the same edge that accepts a packet's last byte, or the edge that takes a register write. The bench drives every input on the falling edge and records the write port on each following falling edge. It waits one further falling edge after the last stimulus before comparing the status word, the interrupt and the recorded buffer contents. This places every sample at least half a cycle after the edge where the result is due. A packet sweep fills the whole buffer and checks every byte, the count and the flags after each packet.

// File: rtl/ts_buf_writer_pkg.sv
package ts_buf_writer_pkg;
  localparam int CNT_LSB  = 24;
  localparam int B_DONE_M = 17;
  localparam int B_DONE   = 16;
  localparam int B_RUN    = 15;
  localparam int B_OVF_M  = 14;
  localparam int B_AF_M   = 13;
  localparam int B_LCK_M  = 12;
  localparam int B_OVF    = 11;
  localparam int B_AF     = 10;
  localparam int B_LCK    = 9;
  localparam int B_ACK    = 8;
  localparam int THR_W    = 7;

  typedef struct packed {
    logic done;
    logic ovf;
    logic afull;
    logic lock;
  } evt_t;
endpackage

// File: rtl/ts_buf_wr_ctrl.sv
module ts_buf_wr_ctrl #(
  parameter int PKT_BYTES = 188,
  parameter int BUF_PKTS  = 8,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(BUF_PKTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rewind_i,
  input  logic [ADDR_W-1:0] rewind_addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pkt_end_o,
  output logic              ovf_evt_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_PKTS);

  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              drop_q;
  logic              accept, start, last, drop_now, wr;

  always_comb begin
    accept    = byte_valid_i && run_i && !rewind_i;
    start     = accept && (idx_q == '0);
    last      = accept && (idx_q == LAST_IDX);
    drop_now  = start ? (cnt_q == FULL_CNT) : drop_q;
    wr        = accept && !drop_now;
    pkt_end_o = last && !drop_now;
    ovf_evt_o = start && (cnt_q == FULL_CNT);
  end

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      drop_q     <= 1'b0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= wr;
      if (wr) begin
        mem_addr_o <= ptr_q;
        mem_data_o <= byte_i;
      end
      if (rewind_i) begin
        ptr_q  <= rewind_addr_i;
        cnt_q  <= '0;
        idx_q  <= '0;
        drop_q <= 1'b0;
      end else if (!run_i) begin
        ptr_q  <= base_i;
        cnt_q  <= '0;
        idx_q  <= '0;
        drop_q <= 1'b0;
      end else if (accept) begin
        idx_q  <= last ? '0 : idx_q + IDX_W'(1);
        drop_q <= last ? 1'b0 : drop_now;
        if (wr)        ptr_q <= ptr_q + ADDR_W'(1);
        if (pkt_end_o) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ts_buf_csr.sv
module ts_buf_csr
  import ts_buf_writer_pkg::*;
#(
  parameter int BUF_PKTS = 8,
  parameter int ADDR_W   = 32,
  localparam int CNT_W   = $clog2(BUF_PKTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              lock_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pkt_end_i,
  input  logic              ovf_evt_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              run_o,
  output logic              rewind_o,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  evt_t             flags_q, masks_q, evt;
  logic [THR_W-1:0] thr_q;
  logic             lock_q;
  logic             csr_wr, ack;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    csr_wr    = reg_we_i && !reg_sel_i;
    ack       = csr_wr && reg_wdata_i[B_ACK];
    rewind_o  = reg_we_i && reg_sel_i;
    cnt_nxt   = cnt_i + CNT_W'(1);
    evt.done  = pkt_end_i && (THR_W'(cnt_nxt) == thr_q);
    evt.afull = pkt_end_i && (cnt_nxt == CNT_W'(BUF_PKTS - 1));
    evt.ovf   = ovf_evt_i;
    evt.lock  = lock_i && !lock_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      masks_q <= '1;
      thr_q   <= THR_W'(BUF_PKTS / 2);
      run_o   <= 1'b0;
      base_o  <= '0;
      lock_q  <= 1'b0;
    end else begin
      lock_q  <= lock_i;
      // events set after the acknowledge clear, so a coincident event survives
      flags_q <= (flags_q & ~{4{ack}}) | evt;
      if (csr_wr) begin
        masks_q <= {reg_wdata_i[B_DONE_M], reg_wdata_i[B_OVF_M],
                    reg_wdata_i[B_AF_M], reg_wdata_i[B_LCK_M]};
        thr_q   <= reg_wdata_i[THR_W-1:0];
        run_o   <= reg_wdata_i[B_RUN];
      end
      if (rewind_o) base_o <= reg_wdata_i[ADDR_W-1:0];
    end
  end

  always_comb begin
    status_o                          = '0;
    status_o[CNT_LSB +: 8]            = 8'(cnt_i);
    status_o[B_DONE_M]                = masks_q.done;
    status_o[B_DONE]                  = flags_q.done;
    status_o[B_RUN]                   = run_o;
    status_o[B_OVF_M]                 = masks_q.ovf;
    status_o[B_AF_M]                  = masks_q.afull;
    status_o[B_LCK_M]                 = masks_q.lock;
    status_o[B_OVF]                   = flags_q.ovf;
    status_o[B_AF]                    = flags_q.afull;
    status_o[B_LCK]                   = flags_q.lock;
    status_o[THR_W-1:0]               = thr_q;
  end

  assign irq_o = |(flags_q & ~masks_q);
endmodule

// File: rtl/ts_buf_writer.sv
module ts_buf_writer #(
  parameter int PKT_BYTES = 188,
  parameter int BUF_PKTS  = 8,
  parameter int ADDR_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              lock_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(BUF_PKTS + 1);

  logic [ADDR_W-1:0] base;
  logic              run, rewind, pkt_end, ovf_evt;
  logic [CNT_W-1:0]  cnt;

  ts_buf_wr_ctrl #(
    .PKT_BYTES(PKT_BYTES), .BUF_PKTS(BUF_PKTS), .ADDR_W(ADDR_W)
  ) i_wr_ctrl (
    .clk_i, .rst_ni,
    .run_i(run), .rewind_i(rewind), .rewind_addr_i(reg_wdata_i[ADDR_W-1:0]),
    .base_i(base), .byte_valid_i, .byte_i,
    .mem_we_o, .mem_addr_o, .mem_data_o,
    .cnt_o(cnt), .pkt_end_o(pkt_end), .ovf_evt_o(ovf_evt)
  );

  ts_buf_csr #(.BUF_PKTS(BUF_PKTS), .ADDR_W(ADDR_W)) i_csr (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .lock_i,
    .cnt_i(cnt), .pkt_end_i(pkt_end), .ovf_evt_i(ovf_evt),
    .base_o(base), .run_o(run), .rewind_o(rewind),
    .status_o, .irq_o
  );
endmodule

// File: rtl/ts_buf_writer_chk.sv
module ts_buf_writer_chk #(
  parameter int BUF_PKTS = 8,
  parameter int ADDR_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic              ack_i,
  input logic              byte_valid_i,
  input logic              lock_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [7:0]        cnt_i,
  input logic              run_i,
  input logic [3:0]        flags_i,
  input logic [3:0]        masks_i,
  input logic              irq_i
);
  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && $past(mem_we_i)) |-> mem_addr_i == $past(mem_addr_i) + ADDR_W'(1));

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 8'd1 || cnt_i == 8'd0));

  a_r6_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= 8'(BUF_PKTS));

  a_r8_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masks_i == 4'hf) |-> !irq_i);

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i && ack_i && !byte_valid_i && !lock_i) |=> flags_i == 4'h0);

  a_r10_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!mem_we_i && cnt_i == 8'd0));

  a_r11_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i) |=> (cnt_i == 8'd0 && !mem_we_i));
endmodule

bind ts_buf_writer ts_buf_writer_chk #(.BUF_PKTS(BUF_PKTS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .ack_i(reg_wdata_i[8]), .byte_valid_i(byte_valid_i), .lock_i(lock_i),
  .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o), .cnt_i(status_o[31:24]),
  .run_i(status_o[15]), .flags_i({status_o[16], status_o[11:9]}),
  .masks_i({status_o[17], status_o[14:12]}), .irq_i(irq_o)
);

// File: tb/test_ts_buf_writer.sv
`timescale 1ns/1ps
module test_ts_buf_writer;
  localparam int PB = 188;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        lock = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  logic [7:0] mem [0:4095];
  logic [31:0] ctrl;

  always #10 clk = ~clk;

  ts_buf_writer i_ts_buf_writer (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_d),
    .lock_i(lock), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .status_o(status), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      mem[mem_addr[11:0]] = mem_data;
      wcount++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] seed, input bit ack_last);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_d = seed + 8'(i);
      if (ack_last && i == PB - 1) begin
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl | 32'h100;
      end
    end
    @(negedge clk);
    byte_valid = 1'b0; reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic verify_pkt(input string req, input int addr, input logic [7:0] seed);
    int bad = 0;
    for (int i = 0; i < PB; i++)
      if (mem[(addr + i) % 4096] !== seed + 8'(i)) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h0002_7004);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 writes", 32'(wcount), 32'd0);

    // R10 bytes ignored while halted
    send_pkt(8'h11, 1'b0);
    chk("R10 halted writes", 32'(wcount), 32'd0);
    chk("R10 halted count", {24'd0, status[31:24]}, 32'd0);

    csr_write(1'b1, 32'h100);
    ctrl = 32'h0000_8004;
    csr_write(1'b0, ctrl);
    chk("R8 status unmasked", status, 32'h0000_8004);

    // fill sweep: R2 R3 R4 R5
    for (int p = 0; p < NP; p++) begin
      logic [7:0] s;
      s = 8'(p * 37 + 1);
      send_pkt(s, 1'b0);
      chk("R3 count", {24'd0, status[31:24]}, 32'(p + 1));
      verify_pkt("R2 data", 32'h100 + p * PB, s);
      chk("R2 write total", 32'(wcount), 32'((p + 1) * PB));
      if (p == 3) begin
        chk("R4 done flag", {31'd0, status[16]}, 32'd1);
        chk("R8 irq done", {31'd0, irq}, 32'd1);
        csr_write(1'b0, ctrl | 32'h100);
        chk("R9 flags cleared", {16'd0, status[16], status[11:9], 12'd0}, 32'd0);
        chk("R9 ack reads 0", {31'd0, status[8]}, 32'd0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);
      end else if (p == 6) begin
        chk("R5 afull flag", {31'd0, status[10]}, 32'd1);
        chk("R8 irq afull", {31'd0, irq}, 32'd1);
        csr_write(1'b0, ctrl | 32'h100);
      end else begin
        chk("R4 R5 no flags", {16'd0, status[16], status[11:9], 12'd0}, 32'd0);
      end
    end
    chk("R3 full status", status, 32'h0800_8004);

    // R6 overflow
    w0 = wcount;
    send_pkt(8'hc3, 1'b0);
    chk("R6 no writes", 32'(wcount - w0), 32'd0);
    chk("R6 count held", {24'd0, status[31:24]}, 32'd8);
    chk("R6 ovf flag", {31'd0, status[11]}, 32'd1);
    chk("R8 irq ovf", {31'd0, irq}, 32'd1);

    // R8 masking keeps flag
    csr_write(1'b0, ctrl | 32'h4000);
    chk("R8 masked irq", {31'd0, irq}, 32'd0);
    chk("R8 flag kept", {31'd0, status[11]}, 32'd1);
    csr_write(1'b0, ctrl | 32'h100);

    // R11 rewind with a byte in the same cycle
    w0 = wcount;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h900;
    byte_valid = 1'b1; byte_d = 8'haa;
    @(negedge clk);
    reg_we = 1'b0; byte_valid = 1'b0;
    @(negedge clk);
    chk("R11 count zero", {24'd0, status[31:24]}, 32'd0);
    chk("R11 byte ignored", 32'(wcount - w0), 32'd0);
    send_pkt(8'h55, 1'b0);
    verify_pkt("R11 new base", 32'h900, 8'h55);
    chk("R11 count one", {24'd0, status[31:24]}, 32'd1);

    // R4 threshold 2
    ctrl = 32'h0000_8002;
    csr_write(1'b0, ctrl | 32'h100);
    send_pkt(8'h60, 1'b0);
    chk("R4 thr2 done", {31'd0, status[16]}, 32'd1);
    csr_write(1'b0, ctrl | 32'h100);

    // R10 stream reset restarts at base
    csr_write(1'b0, ctrl & ~32'h8000);
    chk("R10 count cleared", {24'd0, status[31:24]}, 32'd0);
    csr_write(1'b0, ctrl);
    send_pkt(8'h77, 1'b0);
    verify_pkt("R10 restart at base", 32'h900, 8'h77);
    chk("R10 count", {24'd0, status[31:24]}, 32'd1);

    // R9 event wins over coincident ack
    send_pkt(8'h81, 1'b1);
    chk("R9 event wins", {31'd0, status[16]}, 32'd1);
    chk("R9 count two", {24'd0, status[31:24]}, 32'd2);
    csr_write(1'b0, ctrl | 32'h100);

    // R7 lock edge
    @(negedge clk);
    lock = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 lock flag", {31'd0, status[9]}, 32'd1);
    chk("R8 irq lock", {31'd0, irq}, 32'd1);
    csr_write(1'b0, ctrl | 32'h100);
    repeat (3) @(negedge clk);
    chk("R7 no retrigger", {31'd0, status[9]}, 32'd0);
    lock = 1'b0;

    // R4 threshold 0 never fires
    ctrl = 32'h0000_8000;
    csr_write(1'b0, ctrl | 32'h100);
    csr_write(1'b1, 32'h200);
    for (int p = 0; p < 3; p++) begin
      send_pkt(8'(p + 9), 1'b0);
      chk("R4 thr0 no done", {31'd0, status[16]}, 32'd0);
    end
    verify_pkt("R2 rewound data", 32'h200 + 2 * PB, 8'd11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule